// File: doc/BRIEF.md
# Prescaled Reload Down-Counter Timer

A multi-channel interval timer for a small processor subsystem. Every channel owns a down counter and a reload value. All channels advance together on a common tick, which is the system clock divided by a fixed ratio. A channel that reaches zero raises its expiry flag. On the following tick it starts again from its reload value, so a reload value of N gives a period of N+1 ticks. An expiry can raise the channel's interrupt line, toggle the timer output pin, or do both, and each of these has its own enable.

Software reaches the block through a plain register port. Each channel has a counter slot and a reload slot, and one shared control/status word holds the run bits, the interrupt enables, the pin-output enable and the expiry flags. To acknowledge an expiry, software reads the status word while the flag is set and then reads that channel's counter. The pin is shared with an address line at chip level. This block supplies only the pin value and an output-enable for the multiplexer.

Top module: `reload_tick_timer`

## Requirements
- R1: After reset every counter and every reload value reads all ones, and the control/status word reads zero. All interrupt lines, the timer output and its output-enable are low.
- R2: A running channel decrements once every DIV clocks. The first decrement comes DIV clocks after the write that sets its run bit, when no channel was running before that write.
- R3: A channel expires on the tick that brings its count to zero. On the next tick it loads its reload value, so it expires every reload+1 ticks.
- R4: Expiry sets the channel's flag, which is bit 8+ch of the status word. Interrupt line ch equals that flag ANDed with the interrupt enable, bit NCH+ch.
- R5: A flag clears only when the status word is read while the flag is set and that channel's counter is read afterwards. A counter read with no status read before it leaves the flag set.
- R6: The run bit is bit ch. While it is clear the counter holds its value and a counter write loads it. While it is set, counter writes are ignored. Reload writes take effect at any time.
- R7: While no channel runs, the prescaler is held at phase zero. A restart after a stop in mid-interval therefore waits a full DIV clocks for the first tick.
- R8: While the output-enable bit (bit 2*NCH) is set, the timer output toggles on each expiry of channel OUT_CH (the last channel). While the bit is clear the output holds. The bit also drives the output-enable port.
- R9: Address 2*ch selects the counter of channel ch and 2*ch+1 its reload value. Address 2*NCH selects the control/status word. Channels run independently of each other.
- R10: A channel with a reload value of zero expires on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW | Register select |
| wr_en | input | 1 | Write strobe, acts at the clock edge |
| rd_en | input | 1 | Read strobe, its side effects act at the clock edge |
| wdata | input | CW | Write data |
| rdata | output | CW | Read data for addr, combinational |
| irq | output | NCH | Per-channel interrupt lines |
| tout | output | 1 | Timer output pin value |
| tout_oe | output | 1 | Selects the timer output onto the shared pin |

## Verification
The bench builds the block with two channels, 16-bit counters and a divide-by-4 prescaler. The short ratio puts full expiry and reload cycles, including a zero reload that toggles the pin on every tick, within a few dozen clocks. Each counter step can then be sampled on the exact clock where it is due. Mid-interval stops and restarts, and both orders of acknowledge reads, are driven at known prescaler phases. This shows that the prescaler resets and that the flag clears only in the defined read order.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  // bit position of channel 0's expiry flag in the control/status word
  localparam int FLAG_BASE = 8;

  function automatic int cnt_slot(input int ch);
    return 2 * ch;
  endfunction

  function automatic int rld_slot(input int ch);
    return 2 * ch + 1;
  endfunction

  function automatic int ctl_slot(input int nch);
    return 2 * nch;
  endfunction
endpackage

// File: rtl/rtt_prescaler.sv
module rtt_prescaler #(
  parameter int DIV = 20,
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  output logic          tick,
  output logic [PW-1:0] phase
);
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)             phase <= '0;
    else if (!enable)       phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                    phase <= phase + PW'(1);
  end

  assign tick = enable && (phase == LAST);
endmodule

// File: rtl/rtt_channel.sv
module rtt_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic          cnt_we,
  input  logic          rld_we,
  input  logic [CW-1:0] wdata,
  input  logic          stat_rd,
  input  logic          cnt_rd,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] rld,
  output logic          flag,
  output logic          expire
);
  // next count on an active tick: reload from zero, else step down
  function automatic logic [CW-1:0] step(input logic [CW-1:0] c, input logic [CW-1:0] r);
    return (c == '0) ? r : c - CW'(1);
  endfunction

  logic          adv;
  logic [CW-1:0] nxt;
  logic          armed;

  assign adv    = tick && run;
  assign nxt    = step(cnt, rld);
  assign expire = adv && (nxt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt <= '1;
    else if (adv)             cnt <= nxt;
    else if (cnt_we && !run)  cnt <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rld <= '1;
    else if (rld_we) rld <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (expire)                flag <= 1'b1;
      else if (cnt_rd && armed)  flag <= 1'b0;
      if (cnt_rd)                armed <= 1'b0;
      else if (stat_rd && flag)  armed <= 1'b1;
    end
  end
endmodule

// File: rtl/reload_tick_timer.sv
module reload_tick_timer
  import rtt_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int CW     = 16,
  parameter int DIV    = 20,
  parameter int OUT_CH = NCH - 1,
  localparam int AW    = $clog2(2 * NCH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic [NCH-1:0] irq,
  output logic          tout,
  output logic          tout_oe
);
  localparam int CTLW = 2 * NCH + 1;
  localparam int PW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [AW-1:0] CTL_A = AW'(ctl_slot(NCH));

  logic [CTLW-1:0]         ctl_q;
  logic [NCH-1:0]          run, ien;
  logic                    oen;
  logic                    any_run, tick;
  logic [PW-1:0]           phase;
  logic                    ctl_we, stat_rd;
  logic [NCH-1:0]          cnt_we, rld_we, cnt_rd, flag, expire;
  logic [NCH-1:0][CW-1:0]  cnt_a, rld_a;
  logic                    tout_q;

  assign run     = ctl_q[NCH-1:0];
  assign ien     = ctl_q[2*NCH-1:NCH];
  assign oen     = ctl_q[2*NCH];
  assign any_run = |run;
  assign ctl_we  = wr_en && (addr == CTL_A);
  assign stat_rd = rd_en && (addr == CTL_A);

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_we) ctl_q <= wdata[CTLW-1:0];
  end

  rtt_prescaler #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .enable(any_run), .tick(tick), .phase(phase)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign cnt_we[c] = wr_en && (addr == AW'(cnt_slot(c)));
    assign rld_we[c] = wr_en && (addr == AW'(rld_slot(c)));
    assign cnt_rd[c] = rd_en && (addr == AW'(cnt_slot(c)));

    rtt_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run(run[c]),
      .cnt_we(cnt_we[c]), .rld_we(rld_we[c]), .wdata(wdata),
      .stat_rd(stat_rd), .cnt_rd(cnt_rd[c]),
      .cnt(cnt_a[c]), .rld(rld_a[c]), .flag(flag[c]), .expire(expire[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      tout_q <= 1'b0;
    else if (oen && expire[OUT_CH])  tout_q <= ~tout_q;
  end

  assign tout    = tout_q;
  assign tout_oe = oen;
  assign irq     = flag & ien;

  always_comb begin
    rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (addr == AW'(cnt_slot(c))) rdata = cnt_a[c];
      if (addr == AW'(rld_slot(c))) rdata = rld_a[c];
    end
    if (addr == CTL_A) begin
      rdata[CTLW-1:0] = ctl_q;
      for (int c = 0; c < NCH; c++) rdata[FLAG_BASE + c] = flag[c];
    end
  end
endmodule

// File: rtl/rtt_chk.sv
module rtt_chk #(
  parameter int NCH    = 2,
  parameter int CW     = 16,
  parameter int DIV    = 20,
  parameter int OUT_CH = NCH - 1,
  localparam int PW    = (DIV > 1) ? $clog2(DIV) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [PW-1:0]          phase,
  input logic                   tick,
  input logic [NCH-1:0]         run,
  input logic                   oen,
  input logic                   tout_q,
  input logic [NCH-1:0][CW-1:0] cnt_a,
  input logic [NCH-1:0][CW-1:0] rld_a,
  input logic [NCH-1:0]         cnt_we,
  input logic [NCH-1:0]         expire,
  input logic [NCH-1:0]         flag
);
  // clocks since the last tick, valid only across an unbroken running stretch
  logic [31:0] gap;
  logic        seen;

  always_ff @(posedge clk) begin
    if (!rst_n || !(|run)) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (tick) begin
      gap  <= '0;
      seen <= 1'b1;
    end else begin
      gap  <= gap + 32'd1;
    end
  end

  AST_PRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(|run) |=> (phase == '0)); // R7

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && seen && (|run)) |-> (gap == 32'(DIV - 1))); // R2

  AST_TOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !oen |=> $stable(tout_q)); // R8

  AST_TOUT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (oen && expire[OUT_CH]) |=> (tout_q != $past(tout_q))); // R8

  for (genvar c = 0; c < NCH; c++) begin : g_a
    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[c] && !cnt_we[c]) |=> $stable(cnt_a[c])); // R6

    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && run[c] && (cnt_a[c] == '0)) |=> (cnt_a[c] == $past(rld_a[c]))); // R3

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      expire[c] |=> flag[c]); // R4
  end
endmodule

bind reload_tick_timer rtt_chk #(.NCH(NCH), .CW(CW), .DIV(DIV), .OUT_CH(OUT_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .tick(tick), .run(run), .oen(oen),
  .tout_q(tout_q), .cnt_a(cnt_a), .rld_a(rld_a), .cnt_we(cnt_we),
  .expire(expire), .flag(flag)
);

// File: tb/reload_tick_timer_tb.sv
`timescale 1ns/1ps
module reload_tick_timer_tb;
  localparam int PS = 4;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic [1:0]    irq;
  logic          tout, tout_oe;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk; // 50 MHz

  reload_tick_timer #(.NCH(2), .CW(16), .DIV(PS)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq(irq), .tout(tout), .tout_oe(tout_oe)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 v = rdata;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic peek(input logic [AW-1:0] a, output logic [15:0] v);
    addr = a; #1 v = rdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    for (int a = 0; a < 4; a++) begin
      peek(AW'(a), v); chk("R1 counter/reload reset", v, 16'hFFFF);
    end
    peek(3'd4, v); chk("R1 control reset", v, 16'h0000);
    chk("R1 irq reset", irq, 2'b00);
    chk("R1 tout reset", tout, 1'b0);
    chk("R1 tout_oe reset", tout_oe, 1'b0);
  endtask

  task automatic t_count_expire;
    logic [15:0] v;
    wr(3'd0, 16'd3);
    wr(3'd1, 16'd5);
    wr(3'd4, 16'h0005);           // run0 + ien0
    edges(PS - 1);
    peek(3'd0, v); chk("R2 no step before DIV clocks", v, 16'd3);
    edges(1);
    peek(3'd0, v); chk("R2 first step at DIV clocks", v, 16'd2);
    edges(2 * PS - 1);
    peek(3'd0, v); chk("R2 count one before zero", v, 16'd1);
    peek(3'd4, v); chk("R4 flag clear before expiry", v[8], 1'b0);
    edges(1);
    peek(3'd0, v); chk("R3 count reaches zero", v, 16'd0);
    peek(3'd4, v); chk("R4 flag set on expiry", v[8], 1'b1);
    chk("R4 irq0 raised", irq, 2'b01);
    edges(PS);
    peek(3'd0, v); chk("R3 reload on next tick", v, 16'd5);
  endtask

  task automatic t_flag_clear;
    logic [15:0] v;
    wr(3'd4, 16'h0004);           // stop, keep ien0
    rd(3'd0, v);
    peek(3'd4, v); chk("R5 counter read alone keeps flag", v[8], 1'b1);
    rd(3'd4, v);   chk("R5 status read shows flag", v[8], 1'b1);
    rd(3'd0, v);
    peek(3'd4, v); chk("R5 flag cleared by status then counter", v[8], 1'b0);
    chk("R5 irq0 dropped", irq, 2'b00);
  endtask

  task automatic t_stop_write;
    logic [15:0] v;
    edges(3 * PS);
    peek(3'd0, v); chk("R6 stopped counter holds", v, 16'd5);
    wr(3'd0, 16'd9);
    peek(3'd0, v); chk("R6 write while stopped loads", v, 16'd9);
    wr(3'd4, 16'h0001);           // run0, E0
    edges(1);                     // after E1
    wr(3'd0, 16'd2);              // at E2, ignored
    peek(3'd0, v); chk("R6 write while running ignored", v, 16'd9);
    edges(2);                     // after E4: first tick
    peek(3'd0, v); chk("R6 running counter steps from old value", v, 16'd8);
    wr(3'd4, 16'h0000);           // stop at E5, mid-interval
    edges(10);
    peek(3'd0, v); chk("R6 counter frozen after stop", v, 16'd8);
  endtask

  task automatic t_prescale_restart;
    logic [15:0] v;
    wr(3'd4, 16'h0001);
    edges(PS - 1);
    peek(3'd0, v); chk("R7 full interval after restart", v, 16'd8);
    edges(1);
    peek(3'd0, v); chk("R7 step after restart", v, 16'd7);
    wr(3'd4, 16'h0000);
  endtask

  task automatic t_tout_reload0;
    logic [15:0] v;
    wr(3'd2, 16'd0);
    wr(3'd3, 16'd0);
    wr(3'd4, 16'h0012);           // run1 + oen
    edges(PS - 1);
    chk("R8 tout before expiry", tout, 1'b0);
    chk("R8 tout_oe follows enable", tout_oe, 1'b1);
    edges(1);
    chk("R10 expiry on first tick toggles tout", tout, 1'b1);
    peek(3'd4, v); chk("R4 flag1 set", v[9], 1'b1);
    chk("R4 irq1 masked by enable", irq, 2'b00);
    edges(PS);
    chk("R10 expiry on next tick toggles back", tout, 1'b0);
    wr(3'd4, 16'h0002);           // oen off, ch1 keeps running
    edges(2 * PS - 1);
    chk("R8 tout holds with enable clear", tout, 1'b0);
    chk("R8 tout_oe low", tout_oe, 1'b0);
    wr(3'd4, 16'h0000);
    peek(3'd0, v); chk("R9 channel 0 untouched by channel 1", v, 16'd7);
  endtask

  task automatic t_map;
    logic [15:0] v;
    wr(3'd3, 16'h0123);
    peek(3'd3, v); chk("R9 reload slot of channel 1", v, 16'h0123);
    peek(3'd1, v); chk("R9 reload slot of channel 0", v, 16'd5);
    wr(3'd4, 16'h000C);           // ien0 + ien1, stopped
    peek(3'd4, v); chk("R9 control/status word", v, 16'h020C);
    chk("R4 irq1 once enabled", irq, 2'b10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog (R1..) actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    edges(3);
    @(negedge clk); rst_n = 1'b1;
    edges(1);
    t_reset;
    t_count_expire;
    t_flag_clear;
    t_stop_write;
    t_prescale_restart;
    t_tout_reload0;
    t_map;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule